// File: doc/BRIEF.md
# Interleaved Cyclic Converter Sequencer

This block is the digital half of a pair of algorithmic (cyclic) analog-to-digital converters that share one timing generator. After a start strobe, a divided-down phase generator walks both converters through one sample slot followed by one slot per result digit. Each digit slot has two halves. In the first half a compare strobe asks the analog stage to evaluate its residue against two thresholds. In the second half a double strobe is issued, together with a subtract-reference or add-reference strobe that follows the digit just resolved. The second converter runs exactly one slot behind the first, so it samples while the first one resolves its first digit.

Every slot yields one three-valued digit (-1, 0, +1) per converter, taken from a flag pair: a high flag (residue above +1/4 of the reference) and a low flag (residue below -1/4 of the reference). Because the digit set is redundant, comparator offsets up to a quarter of the reference only move the residue within the range the later digits can still correct. Once the last digit is in, an align-and-add step weights the digits by powers of two, moves the sum to the unsigned range and saturates it to an 8-bit code. The finished codes leave through one serial shift register, most significant bit first. A frame marker flags the first bit, and a converter index travels with each word.

Top module: `cadc_seq`

## Requirements
- R1: While reset is held and afterwards until a start strobe arrives, every steering strobe, `ser_valid_o` and `frame_o` stay low.
- R2: A start strobe while idle launches exactly one conversion on every converter; a start strobe while a conversion is in progress is ignored and causes no extra sample and no extra output word.
- R3: Each converter receives one sample slot followed by NBITS digit slots; in a digit slot the compare strobe is high for the first half and the double strobe for the second half; sample, compare and double are never high together on one converter.
- R4: Converter k+1 lags converter k by exactly one slot: its sample strobe rises in the cycle in which the sample strobe of converter k falls.
- R5: A digit is +1 when the high flag is set (also when both flags are set), -1 when only the low flag is set, and 0 when neither is set. The flags are taken at the end of the compare half. During the following double half, +1 raises `ref_sub_o`, -1 raises `ref_add_o`, and 0 raises neither.
- R6: The code equals the sum of digit i (i = 0 first) times 2^(NBITS-1-i), plus 2^(NBITS-1), saturated to 0 .. 2^NBITS-1.
- R7: With comparator offsets of magnitude up to a quarter of the reference, the code stays within one LSB of floor(2^NBITS · v / Vref) + 2^(NBITS-1), saturated, for inputs v in [-Vref, Vref].
- R8: Each word is sent as NBITS consecutive bits on `ser_o`, most significant first, with `ser_valid_o` high throughout, `frame_o` high on the first bit only, and `ser_conv_o` holding the converter index; converter 0's word precedes converter 1's word from the same start.
- R9: Each half slot lasts exactly CLK_DIV clock cycles, so a sample strobe lasts 2·CLK_DIV cycles and a compare strobe lasts CLK_DIV cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe for one interleaved conversion |
| cmp_hi_i | input | NUM_CONV | Per converter: residue above the upper threshold |
| cmp_lo_i | input | NUM_CONV | Per converter: residue below the lower threshold |
| samp_o | output | NUM_CONV | Per converter: track/sample the input |
| cmp_o | output | NUM_CONV | Per converter: evaluate the comparator pair |
| ref_sub_o | output | NUM_CONV | Per converter: subtract the reference this half |
| ref_add_o | output | NUM_CONV | Per converter: add the reference this half |
| dbl_o | output | NUM_CONV | Per converter: double the residue this half |
| ser_o | output | 1 | Serial code bit |
| frame_o | output | 1 | High on the first bit of a word |
| ser_valid_o | output | 1 | High while a word bit is on `ser_o` |
| ser_conv_o | output | CW | Index of the converter whose word is on `ser_o` |

## Verification
The bench builds the block with NBITS = 8, NUM_CONV = 2 and CLK_DIV = 2. A short divider keeps each conversion near forty cycles, so many input and offset combinations fit the run, while every half still spans more than one clock and the half-length rule stays observable. A behavioural residue model (r becomes 2r - d·Vref, with a per-converter offset on the thresholds) reacts to the steering strobes. This covers the saturation ends, mid-scale, offsets just under a quarter of the reference in both directions, forced flag patterns including both flags set, and a second start strobe issued mid-conversion.

// File: rtl/cadc_pkg.sv
package cadc_pkg;

    // Two halves of every slot: evaluate the comparators, then update residue.
    typedef enum logic {
        HALF_CMP = 1'b0,
        HALF_UPD = 1'b1
    } half_e;

endpackage

// File: rtl/cadc_timing.sv
module cadc_timing
    import cadc_pkg::*;
#(
    parameter int NBITS    = 8,
    parameter int NUM_CONV = 2,
    parameter int CLK_DIV  = 4,
    localparam int NSLOT   = NBITS + NUM_CONV,
    localparam int SW      = $clog2(NSLOT),
    localparam int DW      = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          start_i,
    output logic          run_o,
    output logic          tick_o,
    output logic [SW-1:0] slot_o,
    output half_e         half_o
);

    typedef struct packed {
        logic          run;
        logic [DW-1:0] div;
        logic [SW-1:0] slot;
        half_e         half;
    } tstate_t;

    tstate_t st_d, st_q;
    logic    tick;

    always_comb begin
        st_d = st_q;
        tick = st_q.run && (st_q.div == DW'(CLK_DIV - 1));
        if (!st_q.run) begin
            if (start_i) begin
                st_d.run  = 1'b1;
                st_d.div  = '0;
                st_d.slot = '0;
                st_d.half = HALF_CMP;
            end
        end else if (tick) begin
            st_d.div = '0;
            if (st_q.half == HALF_CMP) begin
                st_d.half = HALF_UPD;
            end else begin
                st_d.half = HALF_CMP;
                if (st_q.slot == SW'(NSLOT - 1)) begin
                    st_d.run = 1'b0;
                end else begin
                    st_d.slot = st_q.slot + 1'b1;
                end
            end
        end else begin
            st_d.div = st_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign run_o  = st_q.run;
    assign tick_o = tick;
    assign slot_o = st_q.slot;
    assign half_o = st_q.half;

endmodule

// File: rtl/cadc_rsd_fix.sv
module cadc_rsd_fix #(
    parameter int NBITS = 8,
    localparam int AW   = NBITS + 2
) (
    input  logic [NBITS-1:0] pos_i,
    input  logic [NBITS-1:0] neg_i,
    output logic [NBITS-1:0] code_o
);

    logic signed [AW-1:0] pos_w, neg_w, sum;

    // Align the +1 and -1 digit planes at their binary weights, add the
    // mid-scale offset, then clip to the unsigned code range.
    always_comb begin
        pos_w = $signed({2'b00, pos_i});
        neg_w = $signed({2'b00, neg_i});
        sum   = pos_w - neg_w + $signed(AW'(1) <<< (NBITS - 1));
        if (sum < 0)
            code_o = '0;
        else if (sum > $signed(AW'((1 << NBITS) - 1)))
            code_o = '1;
        else
            code_o = sum[NBITS-1:0];
    end

endmodule

// File: rtl/cadc_lane.sv
module cadc_lane
    import cadc_pkg::*;
#(
    parameter int NBITS = 8,
    parameter int LAG   = 0,
    parameter int SW    = 4,
    localparam int BW   = $clog2(NBITS)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic [SW-1:0]    slot_i,
    input  half_e            half_i,
    input  logic             hi_i,
    input  logic             lo_i,
    output logic             samp_o,
    output logic             cmp_o,
    output logic             ref_sub_o,
    output logic             ref_add_o,
    output logic             dbl_o,
    output logic             done_o,
    output logic [NBITS-1:0] code_o
);

    typedef struct packed {
        logic [NBITS-1:0] pos;
        logic [NBITS-1:0] neg;
    } lstate_t;

    lstate_t       st_d, st_q;
    logic          in_win, is_samp, is_dig;
    logic [SW-1:0] loc;
    logic [BW-1:0] bsel;

    always_comb begin
        in_win  = run_i && (slot_i >= SW'(LAG)) && (slot_i <= SW'(LAG + NBITS));
        loc     = slot_i - SW'(LAG);
        is_samp = in_win && (loc == '0);
        is_dig  = in_win && (loc != '0);
        bsel    = BW'(NBITS - int'(loc));

        st_d = st_q;
        if (tick_i && half_i == HALF_CMP) begin
            if (is_samp) begin
                st_d.pos = '0;
                st_d.neg = '0;
            end else if (is_dig) begin
                st_d.pos[bsel] = hi_i;
                st_d.neg[bsel] = lo_i && !hi_i;
            end
        end

        samp_o    = is_samp;
        cmp_o     = is_dig && (half_i == HALF_CMP);
        dbl_o     = is_dig && (half_i == HALF_UPD);
        ref_sub_o = dbl_o && st_q.pos[bsel];
        ref_add_o = dbl_o && st_q.neg[bsel];
        done_o    = tick_i && dbl_o && (loc == SW'(NBITS));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    cadc_rsd_fix #(.NBITS(NBITS)) u_fix (
        .pos_i  (st_q.pos),
        .neg_i  (st_q.neg),
        .code_o (code_o)
    );

endmodule

// File: rtl/cadc_serout.sv
module cadc_serout #(
    parameter int NBITS    = 8,
    parameter int NUM_CONV = 2,
    localparam int CW      = (NUM_CONV > 1) ? $clog2(NUM_CONV) : 1,
    localparam int BW      = $clog2(NBITS)
) (
    input  logic                               clk_i,
    input  logic                               rst_ni,
    input  logic [NUM_CONV-1:0]                done_i,
    input  logic [NUM_CONV-1:0][NBITS-1:0]     code_i,
    output logic                               ser_o,
    output logic                               frame_o,
    output logic                               valid_o,
    output logic [CW-1:0]                      conv_o
);

    typedef struct packed {
        logic [NUM_CONV-1:0][NBITS-1:0] res;
        logic [NUM_CONV-1:0]            pend;
        logic [NBITS-1:0]               sh;
        logic                           act;
        logic [BW-1:0]                  bitc;
        logic [CW-1:0]                  conv;
    } sstate_t;

    sstate_t       st_d, st_q;
    logic [CW-1:0] sel;
    logic          any;

    always_comb begin
        sel = '0;
        any = 1'b0;
        for (int k = NUM_CONV - 1; k >= 0; k--) begin
            if (st_q.pend[k]) begin
                sel = CW'(k);
                any = 1'b1;
            end
        end

        st_d = st_q;
        if (st_q.act) begin
            st_d.sh = {st_q.sh[NBITS-2:0], 1'b0};
            if (st_q.bitc == BW'(NBITS - 1)) st_d.act = 1'b0;
            else                             st_d.bitc = st_q.bitc + 1'b1;
        end else if (any) begin
            st_d.act       = 1'b1;
            st_d.bitc      = '0;
            st_d.sh        = st_q.res[sel];
            st_d.conv      = sel;
            st_d.pend[sel] = 1'b0;
        end

        for (int k = 0; k < NUM_CONV; k++) begin
            if (done_i[k]) begin
                st_d.res[k]  = code_i[k];
                st_d.pend[k] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign ser_o   = st_q.sh[NBITS-1];
    assign valid_o = st_q.act;
    assign frame_o = st_q.act && (st_q.bitc == '0);
    assign conv_o  = st_q.conv;

endmodule

// File: rtl/cadc_seq.sv
module cadc_seq
    import cadc_pkg::*;
#(
    parameter int NBITS    = 8,
    parameter int NUM_CONV = 2,
    parameter int CLK_DIV  = 4,
    localparam int NSLOT   = NBITS + NUM_CONV,
    localparam int SW      = $clog2(NSLOT),
    localparam int CW      = (NUM_CONV > 1) ? $clog2(NUM_CONV) : 1
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                start_i,
    input  logic [NUM_CONV-1:0] cmp_hi_i,
    input  logic [NUM_CONV-1:0] cmp_lo_i,
    output logic [NUM_CONV-1:0] samp_o,
    output logic [NUM_CONV-1:0] cmp_o,
    output logic [NUM_CONV-1:0] ref_sub_o,
    output logic [NUM_CONV-1:0] ref_add_o,
    output logic [NUM_CONV-1:0] dbl_o,
    output logic                ser_o,
    output logic                frame_o,
    output logic                ser_valid_o,
    output logic [CW-1:0]       ser_conv_o
);

    logic                           run, tick;
    logic [SW-1:0]                  slot;
    half_e                          half;
    logic [NUM_CONV-1:0]            done;
    logic [NUM_CONV-1:0][NBITS-1:0] codes;

    cadc_timing #(
        .NBITS    (NBITS),
        .NUM_CONV (NUM_CONV),
        .CLK_DIV  (CLK_DIV)
    ) u_timing (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (start_i),
        .run_o   (run),
        .tick_o  (tick),
        .slot_o  (slot),
        .half_o  (half)
    );

    for (genvar k = 0; k < NUM_CONV; k++) begin : g_lane
        cadc_lane #(
            .NBITS (NBITS),
            .LAG   (k),
            .SW    (SW)
        ) u_lane (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .run_i     (run),
            .tick_i    (tick),
            .slot_i    (slot),
            .half_i    (half),
            .hi_i      (cmp_hi_i[k]),
            .lo_i      (cmp_lo_i[k]),
            .samp_o    (samp_o[k]),
            .cmp_o     (cmp_o[k]),
            .ref_sub_o (ref_sub_o[k]),
            .ref_add_o (ref_add_o[k]),
            .dbl_o     (dbl_o[k]),
            .done_o    (done[k]),
            .code_o    (codes[k])
        );
    end

    cadc_serout #(
        .NBITS    (NBITS),
        .NUM_CONV (NUM_CONV)
    ) u_serout (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .done_i  (done),
        .code_i  (codes),
        .ser_o   (ser_o),
        .frame_o (frame_o),
        .valid_o (ser_valid_o),
        .conv_o  (ser_conv_o)
    );

endmodule

// File: rtl/cadc_seq_chk.sv
module cadc_seq_chk #(
    parameter int NBITS    = 8,
    parameter int NUM_CONV = 2,
    parameter int CLK_DIV  = 4,
    parameter int CW       = 1
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic [NUM_CONV-1:0] samp_o,
    input logic [NUM_CONV-1:0] cmp_o,
    input logic [NUM_CONV-1:0] ref_sub_o,
    input logic [NUM_CONV-1:0] ref_add_o,
    input logic [NUM_CONV-1:0] dbl_o,
    input logic                frame_o,
    input logic                ser_valid_o,
    input logic [CW-1:0]       ser_conv_o
);

    logic [15:0] hc_q;
    logic        cprev_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            hc_q    <= '0;
            cprev_q <= 1'b0;
        end else begin
            hc_q    <= cmp_o[0] ? hc_q + 16'd1 : 16'd0;
            cprev_q <= cmp_o[0];
        end
    end

    // R9: a compare half lasts exactly CLK_DIV cycles
    assert_half_len_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!cmp_o[0] && cprev_q) |-> (hc_q == 16'(CLK_DIV)));

    for (genvar k = 0; k < NUM_CONV; k++) begin : g_conv
        // R3: steering phases of one converter never overlap
        assert_phase_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $onehot0({samp_o[k], cmp_o[k], dbl_o[k]}));
        // R5: reference strobes only in a double half, never both
        assert_ref_gated_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (ref_sub_o[k] || ref_add_o[k]) |-> (dbl_o[k] && !(ref_sub_o[k] && ref_add_o[k])));
    end

    for (genvar k = 1; k < NUM_CONV; k++) begin : g_lag
        // R4: the next converter samples as the previous one stops sampling
        assert_lag_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $fell(samp_o[k-1]) |-> samp_o[k]);
    end

    // R8: frame marks a single valid bit
    assert_frame_valid_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frame_o |-> ser_valid_o);
    assert_frame_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frame_o |=> (!frame_o && ser_valid_o && $stable(ser_conv_o)));

endmodule

bind cadc_seq cadc_seq_chk #(
    .NBITS    (NBITS),
    .NUM_CONV (NUM_CONV),
    .CLK_DIV  (CLK_DIV),
    .CW       (CW)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .samp_o      (samp_o),
    .cmp_o       (cmp_o),
    .ref_sub_o   (ref_sub_o),
    .ref_add_o   (ref_add_o),
    .dbl_o       (dbl_o),
    .frame_o     (frame_o),
    .ser_valid_o (ser_valid_o),
    .ser_conv_o  (ser_conv_o)
);

// File: tb/tb_cadc_seq.sv
`timescale 1ns/1ps
module tb_cadc_seq;

    localparam int CDIV = 2;
    localparam int NB   = 8;
    localparam int VREF = 1024;
    localparam int NV   = 8;
    // v0, v1, offset0, offset1, ideal0, ideal1
    localparam int VEC [NV][6] = '{
        '{   0,  256,    0,    0, 128, 192},
        '{-512,  508,    0,    0,   0, 255},
        '{-300,  100,    0,    0,  53, 153},
        '{1000,-1000,    0,    0, 255,   0},
        '{   0,  256,  200, -200, 128, 192},
        '{-300,  100, -250,  250,  53, 153},
        '{  37,   -9,  100, -100, 137, 125},
        '{ 511, -511,  255, -255, 255,   0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [1:0] hi = '0, lo = '0;
    logic [1:0] samp, cmpx, rsub, radd, dbl;
    logic       ser, frame, sval;
    logic [0:0] sconv;

    always #5 clk = ~clk;

    cadc_seq #(.NBITS(NB), .NUM_CONV(2), .CLK_DIV(CDIV)) dut (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start),
        .cmp_hi_i(hi), .cmp_lo_i(lo),
        .samp_o(samp), .cmp_o(cmpx), .ref_sub_o(rsub), .ref_add_o(radd), .dbl_o(dbl),
        .ser_o(ser), .frame_o(frame), .ser_valid_o(sval), .ser_conv_o(sconv)
    );

    int n_chk = 0, n_bad = 0;
    int vin [2], offs [2], resid [2], esum [2], eidx [2];
    int samp_rise [2], cmp_cnt [2], dbl_cnt [2];
    logic lhi [2], llo [2], psamp [2], pcmp [2], pdbl [2];
    int mode = 0;
    int ncyc = 0, fall0 = -1, rise1 = -2, slen = 0, slen_last = 0;
    int words = 0, wacc = 0, wbits = 0, wconv = 0;
    int got_code [64], got_conv [64];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int clamp(input int x);
        if (x < 0) return 0;
        if (x > 255) return 255;
        return x;
    endfunction

    // Behavioural analog stage and serial collector, all at the falling edge.
    initial begin
        for (int k = 0; k < 2; k++) begin
            psamp[k] = 0; pcmp[k] = 0; pdbl[k] = 0; lhi[k] = 0; llo[k] = 0;
            resid[k] = 0; esum[k] = 0; eidx[k] = 0;
        end
        forever begin
            @(negedge clk);
            ncyc++;
            for (int k = 0; k < 2; k++) begin
                if (samp[k]) resid[k] = vin[k];
                if (samp[k] && !psamp[k]) samp_rise[k]++;
                if (cmpx[k]) begin
                    logic h, l;
                    case (mode)
                        1:       begin h = 1; l = 1; end
                        2:       begin h = 0; l = 1; end
                        3:       begin h = 0; l = 0; end
                        default: begin
                            h = (resid[k] + offs[k]) >  VREF / 4;
                            l = (resid[k] + offs[k]) < -VREF / 4;
                        end
                    endcase
                    hi[k] = h; lo[k] = l; lhi[k] = h; llo[k] = l;
                    if (!pcmp[k]) cmp_cnt[k]++;
                end else begin
                    hi[k] = 0; lo[k] = 0;
                end
                if (dbl[k] && !pdbl[k]) begin
                    int ed;
                    ed = lhi[k] ? 1 : (llo[k] ? -1 : 0);
                    // R5: reference strobe polarity follows the resolved digit
                    check((rsub[k] == (ed == 1)) && (radd[k] == (ed == -1)), "R5 ref strobe",
                          {rsub[k], radd[k]}, ed);
                    if (eidx[k] < NB) esum[k] += ed * (1 << (NB - 1 - eidx[k]));
                    eidx[k]++;
                    resid[k] = 2 * resid[k] - ed * VREF;
                    dbl_cnt[k]++;
                end
            end
            if (samp[0]) slen++;
            else if (psamp[0]) begin slen_last = slen; slen = 0; end
            if (!samp[0] && psamp[0]) fall0 = ncyc;
            if (samp[1] && !psamp[1]) rise1 = ncyc;
            for (int k = 0; k < 2; k++) begin
                psamp[k] = samp[k]; pcmp[k] = cmpx[k]; pdbl[k] = dbl[k];
            end
            if (sval) begin
                if (frame) begin wacc = 0; wbits = 0; wconv = int'(sconv); end
                wacc = (wacc << 1) | int'(ser);
                wbits++;
                if (wbits == NB && words < 64) begin
                    got_code[words] = wacc;
                    got_conv[words] = wconv;
                    words++;
                end
            end
        end
    end

    task automatic run_pair(input int v0, input int v1, input int o0, input int o1,
                            input int m, input bit extra, output int c0, output int c1);
        int base, t;
        vin[0] = v0; vin[1] = v1; offs[0] = o0; offs[1] = o1; mode = m;
        for (int k = 0; k < 2; k++) begin
            esum[k] = 0; eidx[k] = 0; samp_rise[k] = 0; cmp_cnt[k] = 0; dbl_cnt[k] = 0;
        end
        base = words;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (extra) begin
            repeat (15) @(negedge clk);
            start = 1'b1;
            @(negedge clk); start = 1'b0;
        end
        t = 0;
        while (words < base + 2 && t < 2000) begin @(negedge clk); t++; end
        repeat (4) @(negedge clk);
        check(words == base + 2, "R8 word count", words - base, 2);
        c0 = got_code[base]; c1 = got_code[base + 1];
        check(got_conv[base] == 0 && got_conv[base + 1] == 1, "R8 word order",
              got_conv[base] * 10 + got_conv[base + 1], 1);
        for (int k = 0; k < 2; k++) begin
            check(samp_rise[k] == 1, "R2 one sample per start", samp_rise[k], 1);
            check(cmp_cnt[k] == NB && dbl_cnt[k] == NB, "R3 digit slots",
                  cmp_cnt[k] * 100 + dbl_cnt[k], NB * 100 + NB);
        end
        // R6: code from the digits this model resolved
        check(c0 == clamp(esum[0] + 128), "R6 code conv0", c0, clamp(esum[0] + 128));
        check(c1 == clamp(esum[1] + 128), "R6 code conv1", c1, clamp(esum[1] + 128));
    endtask

    initial begin
        int c0, c1, d0, d1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: quiet during reset
        check({samp, cmpx, rsub, radd, dbl, frame, sval} == '0, "R1 reset outputs",
              int'({samp, cmpx, dbl, frame, sval}), 0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        check({samp, cmpx, dbl, sval} == '0 && words == 0, "R1 idle without start",
              words, 0);

        for (int i = 0; i < NV; i++) begin
            run_pair(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], 0, 1'b0, c0, c1);
            d0 = c0 - VEC[i][4]; d1 = c1 - VEC[i][5];
            // R7: within one LSB of ideal, also under threshold offsets
            check(d0 >= -1 && d0 <= 1, "R7 conv0 vs ideal", c0, VEC[i][4]);
            check(d1 >= -1 && d1 <= 1, "R7 conv1 vs ideal", c1, VEC[i][5]);
        end

        check(slen_last == 2 * CDIV, "R9 sample length", slen_last, 2 * CDIV);
        check(fall0 == rise1, "R4 one-slot lag", rise1, fall0);

        run_pair(0, 0, 0, 0, 1, 1'b0, c0, c1);   // both flags: all +1
        check(c0 == 255 && c1 == 255, "R5 both flags count as +1", c0, 255);
        run_pair(0, 0, 0, 0, 2, 1'b0, c0, c1);   // low only: all -1
        check(c0 == 0 && c1 == 0, "R6 saturate low", c0, 0);
        run_pair(0, 0, 0, 0, 3, 1'b0, c0, c1);   // no flag: all 0
        check(c0 == 128 && c1 == 128, "R6 mid-scale", c0, 128);

        run_pair(256, -256, 0, 0, 0, 1'b1, c0, c1);  // R2: extra start mid-run
        check(c0 == 192 && c1 == 64, "R2 code after ignored start", c0 * 1000 + c1, 192064);
        c0 = words;
        repeat (100) @(negedge clk);
        check(words == c0 && samp == '0, "R2 no extra conversion", words, c0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule